// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Shift Engine

This block moves one byte at a time over a four-wire synchronous serial link. It can act as the clock source (master) or follow an external clock (slave). In master mode it divides the system clock to make the serial clock, sends the byte that was written, and receives a byte on the return line. In slave mode it passes the external clock, select and data lines through synchronisers into the system clock domain, and shifts on the edges it sees. Both roles support all four combinations of clock polarity and clock phase. Data moves most significant bit first.

The engine has a single shift register and no transmit buffer. A write is accepted only while no transfer is in progress. A write that arrives during a transfer is dropped and flagged for one cycle, and the byte already on the wire goes on unchanged. When a byte completes, the received value is copied into a parallel read buffer and a one-cycle completion pulse is raised. The `busy` output gives the surrounding register logic the window in which writes collide. Status flags, their clearing and interrupts are handled by that surrounding logic.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `wr_reject` and `rx_data` are all zero, and in master mode `sck_o` sits at the level of `cfg_cpol`.
- R2: In master mode, `sck_o` rests at `cfg_cpol` whenever `busy` is low. Each byte makes exactly 16 transitions of `sck_o`, which therefore ends at `cfg_cpol`.
- R3: In master mode, `cfg_rate` codes 0, 1, 2 and 3 give an `sck_o` period of 2, 4, 16 and 32 system clocks, and the first transition follows half a period after the write. In slave mode `cfg_rate` has no effect.
- R4: Bits travel most significant first on both data lines. With `cfg_cpha`=0 the receiver samples on the leading edge (the edge away from the idle level) and the transmitter changes data on the trailing edge. With `cfg_cpha`=1 data changes on the leading edge and is sampled on the trailing edge. Either way each bit is presented half a clock before it is sampled.
- R5: In master mode, a write while idle makes `busy` high from the next cycle. At the 16th `sck_o` transition, `busy` falls, `done` pulses for one cycle, and `rx_data` takes the received byte in that same cycle.
- R6: A write while `busy` is high produces a one-cycle `wr_reject` in the next cycle. The shifter is not loaded, and the byte being sent stays the original one.
- R7: `miso_oe` is high only in slave mode while `ss_n_i` is low. In master mode `ss_n_i` is ignored.
- R8: As a slave with `cfg_cpha`=0, `busy` rises once the synchronised select is low. `done` pulses and `rx_data` updates after the eighth sampling (leading) edge, and `busy` stays high until select returns high.
- R9: As a slave with `cfg_cpha`=1, `busy` rises on the first leading edge while selected and falls together with the `done` pulse after the eighth sampling (trailing) edge. Select may stay low across consecutive bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| cfg_rate | input | 2 | Master divider code: 0,1,2,3 divide by 2,4,16,32 |
| wr_en | input | 1 | One-cycle write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| busy | output | 1 | Transfer in progress; writes now collide |
| wr_reject | output | 1 | One-cycle pulse: the previous cycle's write was dropped |
| done | output | 1 | One-cycle pulse at byte completion |
| rx_data | output | 8 | Last received byte |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Enable for `sck_o` |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Enable for `mosi_o` |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Serial clock received in slave role |
| mosi_i | input | 1 | Slave data in |
| ss_n_i | input | 1 | Active-low select input for slave role |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Enable for `miso_o` (low means high impedance) |

## Verification
On every cycle, the assertions check the following: the divider count stays inside its half period; the master clock returns to its idle level when a byte ends; `done` never lasts two cycles; a master transfer starts only after a write; the shifter does not move on a rejected write; the bit counter stays in range; and a phase-0 slave holds `busy` after completion while still selected. Only the bench scenarios can show the actual bit order and content on the data lines, the clock period produced by each rate code, that a colliding write leaves the transmitted byte intact, and the different begin and end of the slave transfer window in each phase, including back-to-back bytes under a held select.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    RATE_DIV2  = 2'd0,
    RATE_DIV4  = 2'd1,
    RATE_DIV16 = 2'd2,
    RATE_DIV32 = 2'd3
  } rate_code_e;

  // Number of system clocks per serial clock half period for a rate code.
  function automatic int unsigned half_period(input logic [1:0] code);
    case (rate_code_e'(code))
      RATE_DIV2:  half_period = 1;
      RATE_DIV4:  half_period = 2;
      RATE_DIV16: half_period = 8;
      default:    half_period = 16;
    endcase
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CHAIN = (STAGES < 1) ? 1 : STAGES;

  logic [CHAIN-1:0][W-1:0] chain_q;
  logic [CHAIN-1:0][W-1:0] chain_d;

  generate
    if (CHAIN == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[CHAIN-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {CHAIN{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[CHAIN-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;

  always_comb begin
    half_m1 = CNT_W'(spi_eng_pkg::half_period(rate) - 1);
    tick    = run && (cnt_q == half_m1);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Divider never runs past the half period chosen by the rate code.
  assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= half_m1));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_rate,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              wr_reject,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  output logic              miso_oe
);
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam int EC_W = $clog2(2 * DATA_W);
  localparam logic [NB_W-1:0] NB_FULL   = NB_W'(DATA_W);
  localparam logic [NB_W-1:0] NB_LAST   = NB_W'(DATA_W - 1);
  localparam logic [EC_W-1:0] EDGE_LAST = EC_W'(2 * DATA_W - 1);

  logic rst_q_n;
  spi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  // ---------------- slave-side synchronisers and edge detect
  logic [2:0] pin_s;
  logic       sck_s, ss_s, mosi_s, sck_prev_q;
  spi_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .din({sck_i, ss_n_i, mosi_i}), .dout(pin_s));
  assign {sck_s, ss_s, mosi_s} = pin_s;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) sck_prev_q <= 1'b0;
    else          sck_prev_q <= sck_s;
  end

  logic s_edge, s_lead, s_trail;
  assign s_edge  = sck_s ^ sck_prev_q;
  assign s_lead  = s_edge && (sck_s != cfg_cpol);
  assign s_trail = s_edge && (sck_s == cfg_cpol);

  // ---------------- state
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              out_q, out_d;
  logic [NB_W-1:0]   nb_q, nb_d;
  logic [EC_W-1:0]   ec_q, ec_d;
  logic              sck_q, sck_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              done_q, done_d;
  logic              rej_q, rej_d;

  // ---------------- master clock divider
  logic m_tick;
  spi_rate_gen #(.CNT_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_q_n), .run(cfg_master && busy_q),
    .rate(cfg_rate), .tick(m_tick));

  // ---------------- edge classification shared by both roles
  logic ev_lead, ev_trail, ev_sample, ev_drive;
  always_comb begin
    if (cfg_master) begin
      ev_lead  = m_tick && !ec_q[0];
      ev_trail = m_tick &&  ec_q[0];
    end else begin
      ev_lead  = s_lead;
      ev_trail = s_trail;
    end
    ev_sample = cfg_cpha ? ev_trail : ev_lead;
    ev_drive  = cfg_cpha ? ev_lead  : ev_trail;
  end

  // ---------------- slave transfer window
  logic s_sel, s_start, s_live;
  assign s_sel   = !ss_s;
  assign s_start = s_sel && !busy_q && (cfg_cpha ? s_lead : 1'b1);
  assign s_live  = (busy_q || s_start) && (nb_q != NB_FULL);

  // ---------------- next state
  always_comb begin
    busy_d = busy_q;
    sr_d   = sr_q;
    out_d  = out_q;
    nb_d   = nb_q;
    ec_d   = ec_q;
    sck_d  = sck_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    rej_d  = 1'b0;

    if (cfg_master) begin
      if (!busy_q) begin
        if (wr_en) begin
          busy_d = 1'b1;
          sr_d   = wr_data;
          out_d  = wr_data[DATA_W-1];
          ec_d   = '0;
          nb_d   = '0;
          sck_d  = cfg_cpol;
        end
      end else begin
        rej_d = wr_en;
        if (m_tick) begin
          sck_d = ~sck_q;
          ec_d  = ec_q + 1'b1;
          if (ev_sample) begin
            sr_d = {sr_q[DATA_W-2:0], miso_i};
            nb_d = nb_q + 1'b1;
          end
          if (ev_drive && (ec_q != EDGE_LAST)) out_d = sr_q[DATA_W-1];
          if (ec_q == EDGE_LAST) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            rx_d   = sr_d;
            nb_d   = '0;
          end
        end
      end
    end else if (!s_sel) begin
      busy_d = 1'b0;
      nb_d   = '0;
      if (wr_en) begin
        if (busy_q) begin
          rej_d = 1'b1;
        end else begin
          sr_d  = wr_data;
          out_d = wr_data[DATA_W-1];
        end
      end
    end else begin
      if (s_start) begin
        busy_d = 1'b1;
        nb_d   = '0;
      end
      if (wr_en) begin
        if (busy_q || s_start) begin
          rej_d = 1'b1;
        end else begin
          sr_d  = wr_data;
          out_d = wr_data[DATA_W-1];
        end
      end
      if (s_live && ev_sample) begin
        sr_d = {sr_q[DATA_W-2:0], mosi_s};
        nb_d = nb_q + 1'b1;
        if (nb_q == NB_LAST) begin
          done_d = 1'b1;
          rx_d   = sr_d;
          if (cfg_cpha) begin
            busy_d = 1'b0;
            nb_d   = '0;
          end
        end
      end
      if (s_live && ev_drive) out_d = sr_q[DATA_W-1];
    end
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q <= 1'b0;
      sr_q   <= '0;
      out_q  <= 1'b0;
      nb_q   <= '0;
      ec_q   <= '0;
      sck_q  <= 1'b0;
      rx_q   <= '0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sr_q   <= sr_d;
      out_q  <= out_d;
      nb_q   <= nb_d;
      ec_q   <= ec_d;
      sck_q  <= sck_d;
      rx_q   <= rx_d;
      done_q <= done_d;
      rej_q  <= rej_d;
    end
  end

  // ---------------- outputs
  assign busy      = busy_q;
  assign wr_reject = rej_q;
  assign done      = done_q;
  assign rx_data   = rx_q;
  assign sck_o     = (cfg_master && busy_q) ? sck_q : cfg_cpol;
  assign sck_oe    = cfg_master;
  assign mosi_o    = out_q;
  assign mosi_oe   = cfg_master;
  assign miso_o    = out_q;
  assign miso_oe   = !cfg_master && !ss_n_i;

  // ---------------- assertions
  assert_sck_home_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_master && $fell(busy_q)) |-> (sck_q == cfg_cpol));

  assert_start_on_write_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_master && $rose(busy_q)) |-> $past(wr_en));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_q |=> !done_q);

  assert_reject_no_load_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_q && wr_en && !ev_sample) |=> $stable(sr_q));

  assert_slave_hold_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cfg_master && !cfg_cpha && done_q && !ss_s) |-> busy_q);

  assert_bitcount_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    nb_q <= NB_FULL);
endmodule

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic busy, wr_reject, done;
  logic [7:0] rx_data;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  always #4 clk = ~clk;

  spi_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .wr_reject(wr_reject), .done(done), .rx_data(rx_data),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
    .miso_o(miso_o), .miso_oe(miso_oe));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int half_of(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  // ---------------- behavioural master-mode reference model
  bit mdl_on = 1'b0;
  logic m_busy, m_done, m_rej;
  logic [7:0] m_rx;
  int m_el;
  logic [7:0] sl_byte = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_rej <= 1'b0; m_rx <= 8'h00; m_el <= 0;
    end else if (mdl_on) begin
      m_done <= 1'b0;
      m_rej  <= 1'b0;
      if (!m_busy) begin
        if (wr_en) begin m_busy <= 1'b1; m_el <= 0; end
      end else begin
        if (wr_en) m_rej <= 1'b1;
        m_el <= m_el + 1;
        if (m_el + 1 == 16 * half_of(cfg_rate)) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_rx   <= sl_byte;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_on && rst_n) begin
      logic exp_sck;
      exp_sck = m_busy ? (cfg_cpol ^ logic'((m_el / half_of(cfg_rate)) % 2)) : cfg_cpol;
      chk(sck_o == exp_sck, "R2/R3 sck_o per cycle", sck_o, exp_sck);
      chk(busy == m_busy, "R5 busy per cycle", busy, m_busy);
      chk(done == m_done, "R5 done per cycle", done, m_done);
      chk(wr_reject == m_rej, "R6 wr_reject per cycle", wr_reject, m_rej);
      chk(rx_data == m_rx, "R5 rx_data per cycle", rx_data, m_rx);
    end
  end

  // ---------------- behavioural slave peripheral for master tests
  bit armed = 1'b0;
  int ecount = 0;
  int sl_idx = 0;
  logic prev_sck = 1'b0;
  logic [7:0] cap_mosi = 8'h00;

  always @(negedge clk) begin
    if (!armed) begin
      miso_i = sl_byte[7];
      sl_idx = cfg_cpha ? 7 : 6;
      ecount = 0;
    end else if (sck_o != prev_sck) begin
      logic lead;
      lead = (sck_o != cfg_cpol);
      if (cfg_cpha ? !lead : lead) cap_mosi = {cap_mosi[6:0], mosi_o};
      else if (sl_idx >= 0) begin
        miso_i = sl_byte[sl_idx];
        sl_idx--;
      end
      ecount++;
      if (ecount == 16) armed = 1'b0;
    end
    prev_sck = sck_o;
  end

  int done_cnt = 0;
  always @(negedge clk) if (done) done_cnt++;

  task automatic master_xfer(input logic cp, input logic ph, input logic [1:0] rt,
                             input logic [7:0] tx, input logic [7:0] rxb, input bit collide);
    @(negedge clk);
    cfg_cpol = cp; cfg_cpha = ph; cfg_rate = rt; sl_byte = rxb;
    @(negedge clk);
    @(negedge clk);
    cap_mosi = 8'h00;
    armed = 1'b1;
    wr_en = 1'b1; wr_data = tx;
    @(negedge clk);
    wr_en = 1'b0;
    if (collide) begin
      repeat (5) @(negedge clk);
      wr_en = 1'b1; wr_data = ~tx;
      @(negedge clk);
      wr_en = 1'b0;
      chk(wr_reject == 1'b1, "R6 collision flagged", wr_reject, 1);
    end
    while (armed) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cap_mosi == tx, collide ? "R6 byte on wire unchanged" : "R4 mosi bit order", cap_mosi, tx);
    chk(rx_data == rxb, "R5 received byte", rx_data, rxb);
  endtask

  // ---------------- behavioural master for slave tests
  task automatic slave_byte(input logic [7:0] mo, output logic [7:0] mi);
    mi = 8'h00;
    if (!cfg_cpha) begin
      mosi_i = mo[7];
      for (int i = 7; i >= 0; i--) begin
        repeat (HP) @(negedge clk);
        sck_i = ~cfg_cpol;
        mi[i] = miso_o;
        repeat (HP) @(negedge clk);
        sck_i = cfg_cpol;
        if (i > 0) mosi_i = mo[i-1];
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        repeat (HP) @(negedge clk);
        sck_i = ~cfg_cpol;
        mosi_i = mo[i];
        repeat (HP) @(negedge clk);
        sck_i = cfg_cpol;
        mi[i] = miso_o;
      end
    end
    repeat (HP) @(negedge clk);
  endtask

  task automatic slave_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_up();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(wr_reject == 1'b0, "R1 wr_reject after reset", wr_reject, 0);
    chk(rx_data == 8'h00, "R1 rx_data after reset", rx_data, 0);
    chk(sck_o == cfg_cpol, "R1 sck_o idle after reset", sck_o, cfg_cpol);

    mdl_on = 1'b1;
    master_xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b0, 1'b1, 2'd0, 8'h81, 8'h7E, 1'b0);
    master_xfer(1'b1, 1'b0, 2'd1, 8'h5B, 8'hC6, 1'b0);
    master_xfer(1'b1, 1'b1, 2'd2, 8'hE4, 8'h19, 1'b0);
    master_xfer(1'b0, 1'b0, 2'd1, 8'h96, 8'h69, 1'b1);
    // R7: master ignores a low select
    ss_n_i = 1'b0;
    master_xfer(1'b0, 1'b1, 2'd3, 8'h2D, 8'hF0, 1'b0);
    chk(miso_oe == 1'b0, "R7 miso_oe low in master", miso_oe, 0);
    ss_n_i = 1'b1;
    repeat (2) @(negedge clk);
    mdl_on = 1'b0;

    // ---------------- slave, phase 0
    cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_rate = 2'd0;
    sck_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(miso_oe == 1'b0, "R7 miso_oe off while deselected", miso_oe, 0);
    slave_write(8'hC3);
    chk(wr_reject == 1'b0, "R6 idle slave write accepted", wr_reject, 0);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R8 busy after select low", busy, 1);
    chk(miso_oe == 1'b1, "R7 miso_oe on while selected", miso_oe, 1);
    done_cnt = 0;
    slave_byte(8'h5A, got);
    chk(got == 8'hC3, "R4 slave miso bit order", got, 8'hC3);
    chk(rx_data == 8'h5A, "R8 slave received byte", rx_data, 8'h5A);
    chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
    chk(busy == 1'b1, "R8 busy held until select high", busy, 1);
    slave_write(8'h11);
    chk(wr_reject == 1'b1, "R6 slave write while busy rejected", wr_reject, 1);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R8 busy clears after select high", busy, 0);

    // ---------------- slave, phase 1, rate field set (ignored)
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_rate = 2'd3;
    sck_i = 1'b1;
    repeat (6) @(negedge clk);
    slave_write(8'h96);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R9 no busy before first edge", busy, 0);
    done_cnt = 0;
    slave_byte(8'h3C, got);
    chk(got == 8'h96, "R3 slave ignores rate field, miso byte", got, 8'h96);
    chk(rx_data == 8'h3C, "R9 first byte received", rx_data, 8'h3C);
    chk(busy == 1'b0, "R9 busy ends with done", busy, 0);
    slave_write(8'h21);
    chk(wr_reject == 1'b0, "R9 write accepted between bytes", wr_reject, 0);
    slave_byte(8'hE7, got);
    chk(got == 8'h21, "R9 second byte miso under held select", got, 8'h21);
    chk(rx_data == 8'hE7, "R9 second byte received", rx_data, 8'hE7);
    chk(done_cnt == 2, "R9 two done pulses", done_cnt, 2);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule